// File: doc/BRIEF.md
# Circular trace capture buffer

The block is a trace sink. A trace source presents 32-bit words with a valid strobe and a trigger pulse. While capture is armed, each accepted word is stored into an internal circular RAM at the write pointer. The write pointer advances by one after each stored word and wraps at the RAM depth. On the first wrap a full flag is set, and software then knows that the oldest valid word sits at the current write pointer rather than at address 0.

A host controls the block over a simple single-cycle register bus. Through it the host sets the enables, programs how many words to keep after a trigger, and reads back captured data. Reads of the data port are auto-incrementing, so software can drain the RAM from any start point. Writes to the fill port are also auto-incrementing, so software can preload or clear the RAM.

A manual flush pads the current 4-word frame with zero words up to the next frame boundary. The flush request bit clears itself when the padding is done. The block can stop capture when a flush completes, or a programmed number of words after a trigger.

Top module: `trace_buf_top`

## Requirements
- R1: After reset all writable registers, both pointers, the trigger counter and every RAM word are zero. The depth register at 0x004 reads DEPTH. The flush status register at 0x300 reads 2 (bit 1 set).
- R2: A trace word is stored only when all of these hold: trc_valid_i is high, control bit 0 (0x020) is set, flush control bit 0 (0x304) is set, capture is not stopped, and no flush is in progress. The word is stored at the write pointer (read at 0x018), and the pointer then increments modulo DEPTH.
- R3: Status bit 0 (0x00C) is set when a trace or pad write is made at address DEPTH-1. A host write to the write pointer (0x018) loads it and clears that bit.
- R4: A host read of 0x010 returns the RAM word at the read pointer and then increments the read pointer modulo DEPTH. The read pointer can be read and written at 0x014.
- R5: A host write to 0x024 stores the data at the write pointer and increments that pointer. Such a write never sets the full flag.
- R6: With flush control bit 13 set, the trigger counter (0x01C) decrements on each word stored after the cycle in which a trigger was accepted. Once it reads 0, no further word is stored and capture is stopped. A trigger is accepted only while control bit 0 is set and capture is not stopped. Further triggers before re-arming have no effect.
- R7: With flush control bit 13 clear, capture continues after the trigger counter reaches 0.
- R8: Writing flush control with bit 6 set starts a flush. Starting in the next cycle, one zero word is written per cycle until the write pointer is a multiple of 4. Bit 6 reads 1 until the cycle after the pointer is aligned. Trace words presented during the flush are dropped.
- R9: If flush control bit 12 is set when a flush completes, capture is stopped.
- R10: Flush status bit 1 (0x300) reads 1 while capture is stopped or control bit 0 is clear. Writing control with bit 0 set clears the stopped state and re-arms the trigger.
- R11: Read data appears on bus_rdata_o one cycle after the read request and holds until the next read. Unmapped addresses read 0. Writes to 0x004, 0x00C and 0x300 have no effect.
- R12: In a cycle with a host write to 0x018 or 0x024, no trace word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, registered |
| trc_valid_i | input | 1 | Trace word valid |
| trc_data_i | input | DW | Trace word |
| trc_trig_i | input | 1 | Trigger pulse |

## Verification
Every host read returns its data on the clock edge after the request cycle. The bench model therefore updates its expected read value at that same edge and compares bus_rdata_o at the following falling edge, on every cycle.

Pointer, counter, full and stopped state change at the edge that ends the write, trace or trigger cycle. Reads issued in later cycles see the new values, and the model applies the same one-edge update. A flush request makes bit 6 read 1 for the pad count plus one cycle. Back-to-back reads of 0x304 during a flush therefore check each cycle of that window against the model's pad count.

// File: rtl/trace_buf_pkg.sv
`timescale 1ns/1ps
package trace_buf_pkg;
  localparam int unsigned BUS_AW = 12;

  localparam logic [BUS_AW-1:0] ADR_DEPTH = 12'h004;
  localparam logic [BUS_AW-1:0] ADR_STAT  = 12'h00C;
  localparam logic [BUS_AW-1:0] ADR_RDAT  = 12'h010;
  localparam logic [BUS_AW-1:0] ADR_RPTR  = 12'h014;
  localparam logic [BUS_AW-1:0] ADR_WPTR  = 12'h018;
  localparam logic [BUS_AW-1:0] ADR_TCNT  = 12'h01C;
  localparam logic [BUS_AW-1:0] ADR_CTRL  = 12'h020;
  localparam logic [BUS_AW-1:0] ADR_WDAT  = 12'h024;
  localparam logic [BUS_AW-1:0] ADR_FSTAT = 12'h300;
  localparam logic [BUS_AW-1:0] ADR_FCTRL = 12'h304;

  localparam int unsigned FC_EN       = 0;
  localparam int unsigned FC_FLUSH    = 6;
  localparam int unsigned FC_STOP_FL  = 12;
  localparam int unsigned FC_STOP_TRG = 13;
  localparam int unsigned FS_STOPPED  = 1;

  typedef struct packed {
    logic cap_en;
    logic fmt_en;
    logic stop_fl;
    logic stop_trg;
  } cfg_t;

  typedef struct packed {
    logic wptr_we;
    logic wdat_we;
    logic tcnt_we;
    logic rearm;
    logic flush_req;
  } hcmd_t;
endpackage

// File: rtl/trace_buf_ram.sv
`timescale 1ns/1ps
module trace_buf_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trace_buf_regs.sv
`timescale 1ns/1ps
module trace_buf_regs
  import trace_buf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic              full_i,
  input  logic [DW-1:0]     trig_cnt_i,
  input  logic              busy_i,
  input  logic              stop_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic [AW-1:0]     rd_ptr_o,
  output cfg_t              cfg_o,
  output hcmd_t             cmd_o
);
  logic          wr_acc, rd_acc, stopped;
  logic [DW-1:0] rd_mux;
  logic [AW-1:0] rd_ptr_q;
  cfg_t          cfg_q;
  logic          unused_wbits;

  assign wr_acc  = bus_req_i & bus_we_i;
  assign rd_acc  = bus_req_i & ~bus_we_i;
  assign stopped = stop_i | ~cfg_q.cap_en;
  assign unused_wbits = ^bus_wdata_i;

  always_comb begin
    cmd_o.wptr_we   = wr_acc && (bus_addr_i == ADR_WPTR);
    cmd_o.wdat_we   = wr_acc && (bus_addr_i == ADR_WDAT);
    cmd_o.tcnt_we   = wr_acc && (bus_addr_i == ADR_TCNT);
    cmd_o.rearm     = wr_acc && (bus_addr_i == ADR_CTRL) && bus_wdata_i[0];
    cmd_o.flush_req = wr_acc && (bus_addr_i == ADR_FCTRL) && bus_wdata_i[FC_FLUSH];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      ADR_DEPTH: rd_mux = DW'(DEPTH);
      ADR_STAT:  rd_mux[0] = full_i;
      ADR_RDAT:  rd_mux = ram_rdata_i;
      ADR_RPTR:  rd_mux = DW'(rd_ptr_q);
      ADR_WPTR:  rd_mux = DW'(wr_ptr_i);
      ADR_TCNT:  rd_mux = trig_cnt_i;
      ADR_CTRL:  rd_mux[0] = cfg_q.cap_en;
      ADR_FSTAT: rd_mux[FS_STOPPED] = stopped;
      ADR_FCTRL: begin
        rd_mux[FC_EN]       = cfg_q.fmt_en;
        rd_mux[FC_FLUSH]    = busy_i;
        rd_mux[FC_STOP_FL]  = cfg_q.stop_fl;
        rd_mux[FC_STOP_TRG] = cfg_q.stop_trg;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      rd_ptr_q    <= '0;
      bus_rdata_o <= '0;
    end else begin
      if (rd_acc) begin
        bus_rdata_o <= rd_mux;
        if (bus_addr_i == ADR_RDAT) rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      if (wr_acc) begin
        case (bus_addr_i)
          ADR_RPTR: rd_ptr_q <= bus_wdata_i[AW-1:0];
          ADR_CTRL: cfg_q.cap_en <= bus_wdata_i[0];
          ADR_FCTRL: begin
            cfg_q.fmt_en   <= bus_wdata_i[FC_EN];
            cfg_q.stop_fl  <= bus_wdata_i[FC_STOP_FL];
            cfg_q.stop_trg <= bus_wdata_i[FC_STOP_TRG];
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_ptr_o = rd_ptr_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/trace_buf_capture.sv
`timescale 1ns/1ps
module trace_buf_capture
  import trace_buf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned FRAME = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned FW   = $clog2(FRAME)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  hcmd_t         cmd_i,
  input  logic [DW-1:0] hwdata_i,
  input  logic          trc_valid_i,
  input  logic [DW-1:0] trc_data_i,
  input  logic          trc_trig_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_waddr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          full_o,
  output logic [DW-1:0] trig_cnt_o,
  output logic          busy_o,
  output logic          stop_o,
  output logic          armed_o
);
  logic [AW-1:0] wr_ptr_q;
  logic [DW-1:0] trig_cnt_q;
  logic full_q, busy_q, stop_q, armed_q;
  logic host_ptr, expired, aligned, pad, done, store, wrap_set;

  // frame boundary detect
  if (FRAME > 1) begin : g_frame
    assign aligned = (wr_ptr_q[FW-1:0] == '0);
  end else begin : g_noframe
    assign aligned = 1'b1;
  end

  assign host_ptr = cmd_i.wptr_we | cmd_i.wdat_we;
  assign expired  = armed_q & (trig_cnt_q == '0) & cfg_i.stop_trg;
  assign pad      = busy_q & ~host_ptr & ~aligned;
  assign done     = busy_q & ~host_ptr & aligned;
  assign store    = trc_valid_i & cfg_i.cap_en & cfg_i.fmt_en & ~stop_q
                  & ~expired & ~busy_q & ~host_ptr;
  assign wrap_set = (pad | store) & (wr_ptr_q == AW'(DEPTH - 1));

  assign ram_we_o    = cmd_i.wdat_we | pad | store;
  assign ram_waddr_o = wr_ptr_q;
  assign ram_wdata_o = cmd_i.wdat_we ? hwdata_i : (store ? trc_data_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      full_q     <= 1'b0;
      busy_q     <= 1'b0;
      stop_q     <= 1'b0;
      armed_q    <= 1'b0;
      trig_cnt_q <= '0;
    end else begin
      if (cmd_i.wptr_we)  wr_ptr_q <= hwdata_i[AW-1:0];
      else if (ram_we_o)  wr_ptr_q <= wr_ptr_q + 1'b1;

      if (cmd_i.wptr_we)  full_q <= 1'b0;
      else if (wrap_set)  full_q <= 1'b1;

      if (cmd_i.flush_req) busy_q <= 1'b1;
      else if (done)       busy_q <= 1'b0;

      if (cmd_i.rearm)                           stop_q <= 1'b0;
      else if (expired || (done && cfg_i.stop_fl)) stop_q <= 1'b1;

      if (cmd_i.rearm) armed_q <= 1'b0;
      else if (trc_trig_i && cfg_i.cap_en && !stop_q) armed_q <= 1'b1;

      if (cmd_i.tcnt_we) trig_cnt_q <= hwdata_i;
      else if (store && armed_q && trig_cnt_q != '0) trig_cnt_q <= trig_cnt_q - 1'b1;
    end
  end

  assign wr_ptr_o   = wr_ptr_q;
  assign full_o     = full_q;
  assign trig_cnt_o = trig_cnt_q;
  assign busy_o     = busy_q;
  assign stop_o     = stop_q;
  assign armed_o    = armed_q;
endmodule

// File: rtl/trace_buf_top.sv
`timescale 1ns/1ps
module trace_buf_top
  import trace_buf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned FRAME = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              trc_valid_i,
  input  logic [DW-1:0]     trc_data_i,
  input  logic              trc_trig_i
);
  cfg_t          cfg;
  hcmd_t         cmd;
  logic [AW-1:0] wr_ptr, rd_ptr, ram_waddr;
  logic [DW-1:0] trig_cnt, ram_wdata, ram_rdata;
  logic          full, busy, stop_flag, armed, ram_we;

  trace_buf_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .wr_ptr_i(wr_ptr), .full_i(full), .trig_cnt_i(trig_cnt), .busy_i(busy),
    .stop_i(stop_flag), .ram_rdata_i(ram_rdata), .rd_ptr_o(rd_ptr),
    .cfg_o(cfg), .cmd_o(cmd)
  );

  trace_buf_capture #(.DW(DW), .DEPTH(DEPTH), .FRAME(FRAME)) u_cap (
    .clk_i, .rst_ni, .cfg_i(cfg), .cmd_i(cmd), .hwdata_i(bus_wdata_i),
    .trc_valid_i, .trc_data_i, .trc_trig_i,
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr), .ram_wdata_o(ram_wdata),
    .wr_ptr_o(wr_ptr), .full_o(full), .trig_cnt_o(trig_cnt), .busy_o(busy),
    .stop_o(stop_flag), .armed_o(armed)
  );

  trace_buf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk_i, .rst_ni, .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(rd_ptr), .rdata_o(ram_rdata)
  );
endmodule

// File: rtl/trace_buf_chk.sv
`timescale 1ns/1ps
module trace_buf_chk
  import trace_buf_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned FRAME = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input hcmd_t         cmd,
  input logic          ram_we,
  input logic [AW-1:0] wr_ptr,
  input logic          full,
  input logic          busy,
  input logic          stop_flag,
  input logic          armed,
  input logic [DW-1:0] trig_cnt
);
  assert_wptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we && !cmd.wptr_we |=> wr_ptr == $past(wr_ptr) + AW'(1));

  assert_full_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full) |-> ($past(wr_ptr) == AW'(DEPTH - 1)) && $past(ram_we));

  assert_full_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.wptr_we |=> !full);

  assert_stopped_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_flag && !cmd.wptr_we && !cmd.wdat_we && !busy |=> wr_ptr == $past(wr_ptr));

  assert_tcnt_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !cmd.tcnt_we |=> trig_cnt <= $past(trig_cnt));

  assert_flush_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) && !$past(cmd.flush_req) |-> (int'(wr_ptr) % int'(FRAME)) == 0);
endmodule

bind trace_buf_top trace_buf_chk #(.DW(DW), .DEPTH(DEPTH), .FRAME(FRAME)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd(cmd), .ram_we(ram_we), .wr_ptr(wr_ptr),
  .full(full), .busy(busy), .stop_flag(stop_flag), .armed(armed), .trig_cnt(trig_cnt)
);

// File: tb/trace_buf_top_tb_top.sv
`timescale 1ns/1ps
module trace_buf_top_tb_top;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, tv = 1'b0, tt = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0, td = '0, rdata;

  always #5 clk = ~clk;

  trace_buf_top #(.DW(32), .DEPTH(D), .FRAME(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .trc_valid_i(tv), .trc_data_i(td), .trc_trig_i(tt)
  );

  // behavioural reference model
  logic [31:0] m_mem [D];
  int unsigned m_wp, m_rp;
  logic [31:0] m_tc, m_rd;
  bit m_full, m_cen, m_fen, m_sfi, m_stg, m_busy, m_stop, m_arm;
  int checks = 0, errors = 0, seq = 0;
  string cur_req = "R1";
  bit fin = 0;

  function automatic logic [31:0] m_mux(logic [11:0] a);
    case (a)
      12'h004: return 32'(D);
      12'h00C: return {31'd0, m_full};
      12'h010: return m_mem[m_rp];
      12'h014: return 32'(m_rp);
      12'h018: return 32'(m_wp);
      12'h01C: return m_tc;
      12'h020: return {31'd0, m_cen};
      12'h300: return {30'd0, m_stop | ~m_cen, 1'b0};
      12'h304: return (32'(m_stg) << 13) | (32'(m_sfi) << 12) | (32'(m_busy) << 6) | 32'(m_fen);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_mem[i] = '0;
      m_wp = 0; m_rp = 0; m_tc = 0; m_rd = 0;
      m_full = 0; m_cen = 0; m_fen = 0; m_sfi = 0; m_stg = 0; m_busy = 0; m_stop = 0; m_arm = 0;
    end else begin
      automatic bit hw  = req && we;
      automatic bit hp  = hw && (addr == 12'h018 || addr == 12'h024);
      automatic bit exp_ = m_arm && m_tc == 0 && m_stg;
      automatic bit al  = (m_wp % 4) == 0;
      automatic bit pad = m_busy && !hp && !al;
      automatic bit dn  = m_busy && !hp && al;
      automatic bit go  = tv && m_cen && m_fen && !m_stop && !exp_ && !m_busy && !hp;
      automatic bit trg = tt && m_cen && !m_stop;
      if (req && !we) begin
        m_rd = m_mux(addr);
        if (addr == 12'h010) m_rp = (m_rp + 1) % D;
      end
      if (hw && addr == 12'h018) begin m_wp = wd % D; m_full = 0; end
      else if (hw && addr == 12'h024) begin m_mem[m_wp] = wd; m_wp = (m_wp + 1) % D; end
      else if (pad || go) begin
        m_mem[m_wp] = go ? td : 32'd0;
        if (m_wp == D - 1) m_full = 1;
        m_wp = (m_wp + 1) % D;
      end
      if (hw && addr == 12'h01C) m_tc = wd;
      else if (go && m_arm && m_tc != 0) m_tc = m_tc - 1;
      if (exp_ || (dn && m_sfi)) m_stop = 1;
      if (trg) m_arm = 1;
      if (dn) m_busy = 0;
      if (hw && addr == 12'h014) m_rp = wd % D;
      if (hw && addr == 12'h020) begin
        m_cen = wd[0];
        if (wd[0]) begin m_stop = 0; m_arm = 0; end
      end
      if (hw && addr == 12'h304) begin
        m_fen = wd[0]; m_sfi = wd[12]; m_stg = wd[13];
        if (wd[6]) m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, rdata, m_rd);
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wd = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic stream(input int n, input int t1, input int t2);
    for (int i = 0; i < n; i++) begin
      tv = 1; td = 32'hA500_0000 + 32'(seq); seq++;
      tt = (i == t1) || (i == t2);
      @(negedge clk);
    end
    tv = 0; tt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    cur_req = "R1";
    bus_rd(12'h004); bus_rd(12'h00C); bus_rd(12'h014); bus_rd(12'h018);
    bus_rd(12'h01C); bus_rd(12'h020); bus_rd(12'h300); bus_rd(12'h304); bus_rd(12'h010);
    // R5 host fill
    cur_req = "R5";
    bus_wr(12'h024, 32'h11); bus_wr(12'h024, 32'h22); bus_wr(12'h024, 32'h33); bus_wr(12'h024, 32'h44);
    bus_rd(12'h018); bus_rd(12'h00C);
    bus_wr(12'h018, 0); bus_wr(12'h014, 0);
    for (int i = 0; i < 4; i++) bus_rd(12'h010);
    bus_rd(12'h014);
    // R2 enables gate capture
    cur_req = "R2";
    bus_wr(12'h020, 1);
    stream(3, -1, -1); bus_rd(12'h018);
    bus_wr(12'h304, 1);
    stream(6, -1, -1); bus_rd(12'h018);
    // R3 wrap and clear
    cur_req = "R3";
    stream(12, -1, -1); bus_rd(12'h00C); bus_rd(12'h018);
    bus_wr(12'h018, 0); bus_rd(12'h00C);
    // R4 read pointer wrap
    cur_req = "R4";
    bus_wr(12'h014, 14);
    for (int i = 0; i < 4; i++) bus_rd(12'h010);
    bus_rd(12'h014);
    // R6 post-trigger stop
    cur_req = "R6";
    bus_wr(12'h020, 1); bus_wr(12'h018, 0); bus_wr(12'h01C, 5);
    bus_wr(12'h304, 32'h2001);
    stream(15, 3, 6);
    bus_rd(12'h018); bus_rd(12'h01C); bus_rd(12'h300);
    // R7 no stop without bit 13
    cur_req = "R7";
    bus_wr(12'h020, 1); bus_wr(12'h304, 1); bus_wr(12'h01C, 2);
    stream(8, 1, -1);
    bus_rd(12'h018); bus_rd(12'h01C); bus_rd(12'h300);
    // R8 flush padding
    cur_req = "R8";
    bus_wr(12'h018, 1);
    fork
      stream(10, -1, -1);
      begin
        bus_wr(12'h304, 32'h1041);
        for (int i = 0; i < 5; i++) bus_rd(12'h304);
        bus_rd(12'h018);
      end
    join
    bus_rd(12'h018);
    bus_wr(12'h014, 0);
    for (int i = 0; i < 8; i++) bus_rd(12'h010);
    // R9 stop on flush done
    cur_req = "R9";
    bus_rd(12'h300);
    stream(3, -1, -1); bus_rd(12'h018);
    // R10 stopped flag and rearm
    cur_req = "R10";
    bus_wr(12'h020, 0); bus_rd(12'h300);
    bus_wr(12'h020, 1); bus_rd(12'h300);
    bus_wr(12'h304, 1);
    // R12 host pointer access blocks capture
    cur_req = "R12";
    fork
      stream(8, -1, -1);
      begin
        bus_wr(12'h024, 32'hDEAD); bus_wr(12'h018, 3); bus_wr(12'h024, 32'hBEEF);
      end
    join
    bus_rd(12'h018); bus_wr(12'h014, 0);
    for (int i = 0; i < 12; i++) bus_rd(12'h010);
    // R11 unmapped and read-only
    cur_req = "R11";
    bus_rd(12'h100); bus_wr(12'h004, 5); bus_wr(12'h00C, 1); bus_wr(12'h300, 0);
    bus_rd(12'h004); bus_rd(12'h00C); bus_rd(12'h300); bus_rd(12'h3FC);
    repeat (2) @(negedge clk);
    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!fin) begin
      fin = 1;
      checks++; errors++;
      $display("FAIL %s watchdog: finished=0 expected=1", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule